// File: doc/BRIEF.md
# Receive Error Statistics Counter Bank

This block keeps four clear-on-read statistics counters for the receive side of an Ethernet MAC. At the end of each packet the receive path hands it a status strobe with the packet's byte length and flags. The flags say whether the packet passed the address filter, whether its length was not a whole number of bytes, whether the PHY signalled a receive error during it, and whether it was dropped because the receive FIFO was full. A separate strobe arrives once for each bad line symbol. Each counter applies its own rule to decide whether an event qualifies.

A dropped packet also raises a one-cycle receiver-overrun interrupt pulse. Every packet accepted while receive is enabled, dropped or not, produces one increment pulse for the external total-packets counter and one for the external total-octets counter, with the byte count alongside.

Software reads a counter through a simple read port. The value appears on the data output one cycle later, and the counter clears on that same clock edge.

Top module: `rx_err_stat_bank`

## Requirements
- R1: All counters are 32 bits wide and are zero after reset. Between reads, a counter changes only by +1 per clock.
- R2: A read with `rdEn` high and `rdAddr` at a mapped offset places that counter's value on `rdData` on the next clock edge and clears the counter to zero on the same edge. The mapped offsets are 0x4004 for alignment errors, 0x4008 for bad symbols, 0x400C for receive-error packets and 0x4010 for missed packets.
- R3: While `rxEnable` is 0, none of the four counters increments, whatever the packet and symbol inputs do.
- R4: The alignment-error counter increments on a `pktEnd` cycle only when all of the following hold: `pktAlignErr`=1, `pktFilterPass`=1, `pktLenBytes` ≥ 64, and `miiSlowMode`=1 (MII at 10/100 Mb/s).
- R5: The receive-error counter increments on a `pktEnd` cycle only when all of the following hold: `pktRxErSeen`=1, `pktFilterPass`=1 and `pktLenBytes` ≥ 64.
- R6: The bad-symbol counter increments once for every clock cycle in which `badSymbol` is 1, whether or not a packet end occurs.
- R7: A `pktEnd` with `pktFifoDrop`=1 increments the missed-packet counter. On the next clock edge `overrunIrq` goes high for exactly one cycle.
- R8: Every `pktEnd` while receive is enabled, including dropped packets, produces a one-cycle pulse on `totPktInc` and on `totOctInc` on the next clock edge, with `totOctLen` equal to the packet's byte length.
- R9: When a read clears a counter in the same cycle that an increment for it arrives, the read returns the old value and the counter becomes 1.
- R10: A counter at all-ones stays at all-ones when further increments arrive, instead of wrapping.
- R11: A read of an unmapped offset returns zero and clears no counter. Unmapped offsets are those outside the four listed, or those not a multiple of four bytes from 0x4004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receive enabled |
| miiSlowMode | input | 1 | 1 when running MII at 10 or 100 Mb/s |
| pktEnd | input | 1 | End-of-packet status strobe |
| pktLenBytes | input | 16 | Packet length, destination address through CRC |
| pktFilterPass | input | 1 | Packet passed address filtering |
| pktAlignErr | input | 1 | Packet length not a whole number of bytes |
| pktRxErSeen | input | 1 | PHY receive error seen during packet |
| pktFifoDrop | input | 1 | Packet dropped, FIFO lacked room |
| badSymbol | input | 1 | One bad line symbol received this cycle |
| rdEn | input | 1 | Read request |
| rdAddr | input | 16 | Read byte offset |
| rdData | output | 32 | Read data, valid the cycle after a read |
| overrunIrq | output | 1 | Receiver-overrun interrupt pulse |
| totPktInc | output | 1 | Increment pulse for total packets received |
| totOctInc | output | 1 | Increment pulse for total octets received |
| totOctLen | output | 16 | Octets to add alongside `totOctInc` |

## Verification
The assertions assume that the status flags are sampled only on a `pktEnd` cycle, and that inputs are stable across each rising edge. The stimulus drives every input on the falling edge and holds `pktEnd` high for a single cycle per packet, so each packet is seen exactly once. Reads are one-cycle pulses. The stimulus never issues reads on back-to-back cycles, so `rdData` is examined while it holds the value of one read.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  localparam int NUM_CNT = 4;

  // Index order equals address order: base + 4*index
  typedef struct packed {
    logic missInc;   // index 3
    logic rxErInc;   // index 2
    logic symInc;    // index 1
    logic alignInc;  // index 0
  } cntStrobes_t;
endpackage

// File: rtl/rx_stat_ctrl.sv
module rx_stat_ctrl
  import rx_stat_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             miiSlowMode,
  input  logic             pktEnd,
  input  logic [LEN_W-1:0] pktLenBytes,
  input  logic             pktFilterPass,
  input  logic             pktAlignErr,
  input  logic             pktRxErSeen,
  input  logic             pktFifoDrop,
  input  logic             badSymbol,
  output cntStrobes_t      strobes,
  output logic             overrunIrq,
  output logic             totPktInc,
  output logic             totOctInc,
  output logic [LEN_W-1:0] totOctLen
);
  logic pktSeen;
  logic longEnough;
  logic qualified;

  assign pktSeen    = rxEnable && pktEnd;
  assign longEnough = pktLenBytes >= LEN_W'(MIN_LEN);
  assign qualified  = pktSeen && pktFilterPass && longEnough;

  always_comb begin
    strobes.alignInc = qualified && pktAlignErr && miiSlowMode;
    strobes.rxErInc  = qualified && pktRxErSeen;
    strobes.symInc   = rxEnable && badSymbol;
    strobes.missInc  = pktSeen && pktFifoDrop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrunIrq <= 1'b0;
      totPktInc  <= 1'b0;
      totOctInc  <= 1'b0;
      totOctLen  <= '0;
    end else begin
      overrunIrq <= strobes.missInc;
      totPktInc  <= pktSeen;
      totOctInc  <= pktSeen;
      totOctLen  <= pktSeen ? pktLenBytes : '0;
    end
  end

  // A dropped packet still reaches the totals
  p_irq_with_totals_r8: assert property (@(posedge clk) disable iff (!rstN)
    overrunIrq |-> (totPktInc && totOctInc));

  // Interrupt is a single-cycle pulse per isolated drop
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    (overrunIrq && !$past(strobes.missInc, 2)) |=> (!overrunIrq || $past(strobes.missInc)));
endmodule

// File: rtl/rx_stat_dp.sv
module rx_stat_dp
  import rx_stat_pkg::*;
#(
  parameter int              CNT_W     = 32,
  parameter int              ADDR_W    = 16,
  parameter logic [15:0]     BASE_ADDR = 16'h4004
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobes_t       strobes,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData
);
  localparam int IDX_W = $clog2(NUM_CNT);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CNT-1:0] incVec;
  logic [NUM_CNT-1:0] clrVec;
  logic [ADDR_W-1:0]  offs;
  logic               hit;
  logic [IDX_W-1:0]   idx;
  logic [CNT_W-1:0]   cntQ [NUM_CNT];

  assign incVec = strobes;
  assign offs   = rdAddr - ADDR_W'(BASE_ADDR);
  assign hit    = rdEn && (offs[1:0] == 2'b00) &&
                  (offs[ADDR_W-1:2] < (ADDR_W-2)'(NUM_CNT));
  assign idx    = offs[IDX_W+1:2];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] baseVal;
    assign clrVec[i] = hit && (idx == IDX_W'(i));
    assign baseVal   = clrVec[i] ? '0 : cntQ[i];

    always_ff @(posedge clk) begin
      if (!rstN)
        cntQ[i] <= '0;
      else if (incVec[i] && baseVal != CNT_MAX)
        cntQ[i] <= baseVal + 1'b1;
      else
        cntQ[i] <= baseVal;
    end

    p_clear_on_read_r2: assert property (@(posedge clk) disable iff (!rstN)
      (clrVec[i] && !incVec[i]) |=> (cntQ[i] == '0));
    p_collide_keeps_event_r9: assert property (@(posedge clk) disable iff (!rstN)
      (clrVec[i] && incVec[i]) |=> (cntQ[i] == CNT_W'(1)));
    p_saturate_r10: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ[i] == CNT_MAX && !clrVec[i]) |=> (cntQ[i] == CNT_MAX));
    p_step_one_r1: assert property (@(posedge clk) disable iff (!rstN)
      !clrVec[i] |=> (cntQ[i] == $past(cntQ[i]) || cntQ[i] == $past(cntQ[i]) + 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (rdEn)
      rdData <= hit ? cntQ[idx] : '0;
  end

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !hit) |=> (rdData == '0));
endmodule

// File: rtl/rx_err_stat_bank.sv
module rx_err_stat_bank
  import rx_stat_pkg::*;
#(
  parameter int          CNT_W     = 32,
  parameter int          LEN_W     = 16,
  parameter int          ADDR_W    = 16,
  parameter int          MIN_LEN   = 64,
  parameter logic [15:0] BASE_ADDR = 16'h4004
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              miiSlowMode,
  input  logic              pktEnd,
  input  logic [LEN_W-1:0]  pktLenBytes,
  input  logic              pktFilterPass,
  input  logic              pktAlignErr,
  input  logic              pktRxErSeen,
  input  logic              pktFifoDrop,
  input  logic              badSymbol,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              overrunIrq,
  output logic              totPktInc,
  output logic              totOctInc,
  output logic [LEN_W-1:0]  totOctLen
);
  cntStrobes_t strobes;

  rx_stat_ctrl #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) ctrl_i (
    .clk, .rstN, .rxEnable, .miiSlowMode, .pktEnd, .pktLenBytes,
    .pktFilterPass, .pktAlignErr, .pktRxErSeen, .pktFifoDrop, .badSymbol,
    .strobes, .overrunIrq, .totPktInc, .totOctInc, .totOctLen
  );

  rx_stat_dp #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) dp_i (
    .clk, .rstN, .strobes, .rdEn, .rdAddr, .rdData
  );
endmodule

// File: tb/rx_err_stat_bank_tb_top.sv
module rx_err_stat_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_ALIGN = 16'h4004;
  localparam logic [15:0] A_SYM   = 16'h4008;
  localparam logic [15:0] A_RXER  = 16'h400C;
  localparam logic [15:0] A_MISS  = 16'h4010;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b1, miiSlowMode = 1'b1, pktEnd = 1'b0;
  logic [15:0] pktLenBytes = '0;
  logic pktFilterPass = 1'b0, pktAlignErr = 1'b0, pktRxErSeen = 1'b0, pktFifoDrop = 1'b0;
  logic badSymbol = 1'b0, rdEn = 1'b0, rdEnS = 1'b0;
  logic [15:0] rdAddr = '0;
  logic [31:0] rdData;
  logic overrunIrq, totPktInc, totOctInc;
  logic [15:0] totOctLen;
  logic [2:0] rdDataS;
  logic irqS, tpS, toS;
  logic [15:0] tlS;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_stat_bank dut_i (
    .clk, .rstN, .rxEnable, .miiSlowMode, .pktEnd, .pktLenBytes, .pktFilterPass,
    .pktAlignErr, .pktRxErSeen, .pktFifoDrop, .badSymbol, .rdEn, .rdAddr,
    .rdData, .overrunIrq, .totPktInc, .totOctInc, .totOctLen
  );

  // Narrow copy so saturation is reachable
  rx_err_stat_bank #(.CNT_W(3)) satDut_i (
    .clk, .rstN, .rxEnable, .miiSlowMode, .pktEnd, .pktLenBytes, .pktFilterPass,
    .pktAlignErr, .pktRxErSeen, .pktFifoDrop, .badSymbol, .rdEn(rdEnS), .rdAddr,
    .rdData(rdDataS), .overrunIrq(irqS), .totPktInc(tpS), .totOctInc(toS), .totOctLen(tlS)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pkt(input int len, input bit filt, input bit algn, input bit rxer, input bit drop);
    @(negedge clk);
    pktEnd = 1'b1; pktLenBytes = 16'(len); pktFilterPass = filt;
    pktAlignErr = algn; pktRxErSeen = rxer; pktFifoDrop = drop;
    @(negedge clk);
    pktEnd = 1'b0; pktFilterPass = 1'b0; pktAlignErr = 1'b0;
    pktRxErSeen = 1'b0; pktFifoDrop = 1'b0;
  endtask

  task automatic symbols(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); badSymbol = 1'b1;
    end
    @(negedge clk); badSymbol = 1'b0;
  endtask

  task automatic readReg(input logic [15:0] a, output logic [31:0] v);
    @(negedge clk); rdEn = 1'b1; rdAddr = a;
    @(negedge clk); rdEn = 1'b0; v = rdData;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq after reset", 32'(overrunIrq), 0);
    check("R1 totPktInc after reset", 32'(totPktInc), 0);
    readReg(A_ALIGN, v); check("R1 align reset", v, 0);
    readReg(A_SYM, v);   check("R1 symbol reset", v, 0);
    readReg(A_RXER, v);  check("R1 rxer reset", v, 0);
    readReg(A_MISS, v);  check("R1 missed reset", v, 0);
  endtask

  task automatic t_align();
    logic [31:0] v;
    pkt(64, 1, 1, 0, 0);   // counts, boundary length
    pkt(63, 1, 1, 0, 0);   // too short
    pkt(100, 0, 1, 0, 0);  // filter fail
    miiSlowMode = 1'b0;
    pkt(100, 1, 1, 0, 0);  // wrong mode
    miiSlowMode = 1'b1;
    pkt(1500, 1, 1, 0, 0); // counts
    readReg(A_ALIGN, v); check("R4 align qualified count", v, 2);
    readReg(A_RXER, v);  check("R5 rxer untouched by align", v, 0);
  endtask

  task automatic t_rxer();
    logic [31:0] v;
    pkt(64, 1, 0, 1, 0);
    pkt(63, 1, 0, 1, 0);
    pkt(200, 0, 0, 1, 0);
    miiSlowMode = 1'b0;
    pkt(200, 1, 0, 1, 0);  // mode irrelevant
    miiSlowMode = 1'b1;
    readReg(A_RXER, v); check("R5 rxer qualified count", v, 2);
  endtask

  task automatic t_symbol();
    logic [31:0] v;
    symbols(5);
    readReg(A_SYM, v); check("R6 symbol count", v, 5);
  endtask

  task automatic t_missed();
    logic [31:0] v;
    @(negedge clk);
    pktEnd = 1'b1; pktLenBytes = 16'd40; pktFifoDrop = 1'b1;
    @(negedge clk);
    pktEnd = 1'b0; pktFifoDrop = 1'b0;
    check("R7 overrun pulse", 32'(overrunIrq), 1);
    check("R8 totPktInc on drop", 32'(totPktInc), 1);
    check("R8 totOctInc on drop", 32'(totOctInc), 1);
    check("R8 totOctLen on drop", 32'(totOctLen), 40);
    @(negedge clk);
    check("R7 overrun one cycle", 32'(overrunIrq), 0);
    check("R8 totPktInc one cycle", 32'(totPktInc), 0);
    @(negedge clk);
    pktEnd = 1'b1; pktLenBytes = 16'd300;
    @(negedge clk);
    pktEnd = 1'b0;
    check("R7 no overrun on kept packet", 32'(overrunIrq), 0);
    check("R8 totPktInc on kept packet", 32'(totPktInc), 1);
    check("R8 totOctLen on kept packet", 32'(totOctLen), 300);
    readReg(A_MISS, v); check("R7 missed count", v, 1);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    rxEnable = 1'b0;
    pkt(100, 1, 1, 1, 1);
    check("R3 no totals when disabled", 32'(totPktInc), 0);
    symbols(3);
    rxEnable = 1'b1;
    readReg(A_ALIGN, v); check("R3 align disabled", v, 0);
    readReg(A_SYM, v);   check("R3 symbol disabled", v, 0);
    readReg(A_RXER, v);  check("R3 rxer disabled", v, 0);
    readReg(A_MISS, v);  check("R3 missed disabled", v, 0);
  endtask

  task automatic t_read_clear();
    logic [31:0] v;
    symbols(3);
    readReg(A_SYM, v); check("R2 read value", v, 3);
    @(negedge clk);
    check("R2 rdData holds", rdData, 3);
    readReg(A_SYM, v); check("R2 cleared after read", v, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    symbols(2);
    @(negedge clk); badSymbol = 1'b1; rdEn = 1'b1; rdAddr = A_SYM;
    @(negedge clk); badSymbol = 1'b0; rdEn = 1'b0;
    check("R9 collide returns old", rdData, 2);
    readReg(A_SYM, v); check("R9 collide keeps event", v, 1);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    symbols(3);
    readReg(16'h4014, v); check("R11 above map reads zero", v, 0);
    readReg(16'h4006, v); check("R11 misaligned reads zero", v, 0);
    readReg(16'h4000, v); check("R11 below map reads zero", v, 0);
    readReg(A_SYM, v);    check("R11 nothing cleared", v, 3);
  endtask

  task automatic t_saturate();
    symbols(9);
    @(negedge clk); rdEnS = 1'b1; rdAddr = A_SYM;
    @(negedge clk); rdEnS = 1'b0;
    check("R10 saturated at max", 32'(rdDataS), 7);
    symbols(1);
    @(negedge clk); rdEnS = 1'b1; rdAddr = A_SYM;
    @(negedge clk); rdEnS = 1'b0;
    check("R10 restarts after clear", 32'(rdDataS), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_align();
    t_rxer();
    t_symbol();
    t_missed();
    t_disable();
    t_read_clear();
    t_collide();
    t_unmapped();
    t_saturate();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule